// File: doc/BRIEF.md
# Quadword Access Pair Sequencer

This block splits one 128-bit load or store into two 64-bit doubleword accesses. It presents them one after the other on a ready/valid output. A decoded request is taken in while the sequencer is idle. The request carries the direction, a reservation flag, a prefixed flag, the endian mode, a 32-bit addressing flag, the effective address and three register fields. For each half the sequencer reports:

- the doubleword address;
- the register of the even/odd pair that this half touches;
- whether the pair forms an atomic quadword;
- whether the half must trap.

Trap conditions are checked when the first half is presented. They cover odd pair fields, overlapping base or index registers, and misalignment where a partial access is not allowed. A trap on the first half ends the operation at once, so the second half is never issued. A fault in the middle of the pair therefore cannot leave the base register overwritten.

Top module: `quad_pair_seq`

## Requirements
- R1: `req_ready` is high exactly when no operation is in progress. A request is taken only on a cycle with `req_valid` and `req_ready` both high. Requests offered while an operation is in progress have no effect.
- R2: The first half shows `out_second`=0 and uses `req_ea` as its address. When `req_mode32`=1, bits 63:32 of that address read as zero.
- R3: The second half shows `out_second`=1. Its address is the first-half address with bits 63:3 incremented by one and bits 2:0 kept. The upper 32 bits are masked again in 32-bit mode.
- R4: Bit 0 of `out_reg` is forced to 1 exactly when `out_second` equals (`req_big_endian` OR `req_prefixed`). Bits 4:1 come from `req_rt`. As a result, a non-prefixed little-endian request uses the odd register first, and every other request uses the even register first.
- R5: A half is aligned when its address bits 2:0 are zero and its address bit 3 equals `out_second`. `out_atomic_qw` is set on every aligned half. `out_atomic_last` is set only on an aligned second half.
- R6: A misaligned request with `req_reserve`=1 raises `out_align_trap`.
- R7: A misaligned load with `req_prefixed`=0 and `req_big_endian`=0 raises `out_align_trap`. Misaligned prefixed loads, big-endian loads and ordinary stores do not trap.
- R8: On the first half, `out_illegal` is raised for a load whose `req_rt` equals `req_ra`. It is also raised for a load with `req_reserve`=1 whose `req_rt` equals `req_rb`. Stores do not trap on `req_ra` equality.
- R9: On the first half, `out_illegal` is raised whenever bit 0 of `req_rt` is 1. `out_illegal` is never set on a second half.
- R10: A first half that carries `out_align_trap` or `out_illegal` has `out_last`=1, and the sequencer returns to idle after it is consumed, with no second half. A second half always has `out_last`=1.
- R11: While `out_valid`=1 and `out_ready`=0, every output holds its value.
- R12: After reset, `out_valid`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_load | input | 1 | 1 = load, 0 = store |
| req_reserve | input | 1 | Load-reserve or store-conditional form |
| req_prefixed | input | 1 | Prefixed instruction form |
| req_big_endian | input | 1 | 1 = big-endian mode |
| req_mode32 | input | 1 | 32-bit addressing, upper address half zeroed |
| req_ea | input | 64 | Effective address of the quadword |
| req_rt | input | 5 | Target or source pair field |
| req_ra | input | 5 | Base register field |
| req_rb | input | 5 | Index register field |
| out_valid | output | 1 | A half is presented |
| out_ready | input | 1 | Downstream takes the presented half |
| out_second | output | 1 | 0 = first half, 1 = second half |
| out_last | output | 1 | This half ends the operation |
| out_addr | output | 64 | Doubleword address of this half |
| out_reg | output | 5 | Register used by this half |
| out_atomic_qw | output | 1 | Half belongs to an aligned atomic pair |
| out_atomic_last | output | 1 | Closing half of an atomic pair |
| out_align_trap | output | 1 | Alignment interrupt request |
| out_illegal | output | 1 | Illegal instruction form |

## Verification
Three kinds of wrong internal state show up at the ports. A stale latched first-half address shows on the second half: its address is no longer the first plus eight, or its low bits have changed. A wrong state encoding shows as a second half following a trapped first half, or as `req_ready` staying low one cycle after the last half is consumed. Both become visible within one clock of the handshake that exposes them. Register-order or alignment decode errors appear immediately on the half being presented, because every per-half output is a function of the latched request and the current half.

// File: rtl/qps_pkg.sv
package qps_pkg;

    localparam int QPS_AW  = 64;
    localparam int QPS_RW  = 5;
    localparam int QPS_OFS = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_FIRST  = 2'd1,
        SEQ_SECOND = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic              load;
        logic              reserve;
        logic              prefixed;
        logic              big_endian;
        logic              mode32;
        logic [QPS_AW-1:0] ea;
        logic [QPS_RW-1:0] rt;
        logic [QPS_RW-1:0] ra;
        logic [QPS_RW-1:0] rb;
    } qw_req_t;

    typedef struct packed {
        seq_state_e        st;
        qw_req_t           req;
        logic [QPS_AW-1:0] ea0;
    } seq_regs_t;

endpackage

// File: rtl/qps_addr_gen.sv
module qps_addr_gen #(
    parameter int AW  = 64,
    parameter int OFS = 3
) (
    input  logic [AW-1:0] base_ea,
    input  logic [AW-1:0] prev_ea,
    input  logic          second,
    input  logic          mode32,
    output logic [AW-1:0] ea
);
    localparam int HI = AW - OFS;

    logic [AW-1:0] raw;
    logic [HI-1:0] upper_inc;

    always_comb begin
        upper_inc = prev_ea[AW-1:OFS] + HI'(1);
        raw = second ? {upper_inc, prev_ea[OFS-1:0]} : base_ea;
    end

    generate
        if (AW > 32) begin : g_mask
            always_comb begin
                ea = mode32 ? {{(AW-32){1'b0}}, raw[31:0]} : raw;
            end
        end else begin : g_nomask
            logic unused_m32;
            always_comb begin
                unused_m32 = mode32;
                ea = raw;
            end
        end
    endgenerate

endmodule

// File: rtl/qps_reg_sel.sv
module qps_reg_sel #(
    parameter int RW = 5
) (
    input  logic [RW-1:0] pair_field,
    input  logic          second,
    input  logic          big_endian,
    input  logic          prefixed,
    output logic [RW-1:0] reg_num
);
    logic force_odd;

    always_comb begin
        force_odd = (second == (big_endian | prefixed));
        reg_num   = {pair_field[RW-1:1], pair_field[0] | force_odd};
    end

endmodule

// File: rtl/qps_trap_check.sv
module qps_trap_check #(
    parameter int AW  = 64,
    parameter int RW  = 5,
    parameter int OFS = 3
) (
    input  logic [AW-1:0] ea,
    input  logic          second,
    input  logic          load,
    input  logic          reserve,
    input  logic          prefixed,
    input  logic          big_endian,
    input  logic [RW-1:0] rt,
    input  logic [RW-1:0] ra,
    input  logic [RW-1:0] rb,
    output logic          atomic_qw,
    output logic          atomic_last,
    output logic          align_trap,
    output logic          illegal
);
    logic low_bits_nz;
    logic pair_aligned;
    logic le_plain_load;
    logic overlap;
    logic odd_pair;
    logic unused_hi;

    always_comb begin
        unused_hi     = ^ea[AW-1:OFS+1];
        low_bits_nz   = |ea[OFS-1:0];
        pair_aligned  = !low_bits_nz && (ea[OFS] == second);
        atomic_qw     = pair_aligned;
        atomic_last   = pair_aligned && second;

        le_plain_load = load && !prefixed && !big_endian;
        align_trap    = !pair_aligned && (reserve || le_plain_load);

        overlap  = load && ((rt == ra) || (reserve && (rt == rb)));
        odd_pair = rt[0];
        illegal  = !second && (overlap || odd_pair);
    end

endmodule

// File: rtl/quad_pair_seq.sv
module quad_pair_seq
    import qps_pkg::*;
#(
    parameter int ADDR_W = QPS_AW,
    parameter int REG_W  = QPS_RW,
    parameter int DW_OFS = QPS_OFS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_load,
    input  logic              req_reserve,
    input  logic              req_prefixed,
    input  logic              req_big_endian,
    input  logic              req_mode32,
    input  logic [ADDR_W-1:0] req_ea,
    input  logic [REG_W-1:0]  req_rt,
    input  logic [REG_W-1:0]  req_ra,
    input  logic [REG_W-1:0]  req_rb,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_second,
    output logic              out_last,
    output logic [ADDR_W-1:0] out_addr,
    output logic [REG_W-1:0]  out_reg,
    output logic              out_atomic_qw,
    output logic              out_atomic_last,
    output logic              out_align_trap,
    output logic              out_illegal
);
    seq_regs_t r_q;
    seq_regs_t r_d;

    logic            second_w;
    logic [QPS_AW-1:0] ea_w;
    logic            trap_w;

    assign second_w = (r_q.st == SEQ_SECOND);

    qps_addr_gen #(.AW(QPS_AW), .OFS(DW_OFS)) u_addr (
        .base_ea (r_q.req.ea),
        .prev_ea (r_q.ea0),
        .second  (second_w),
        .mode32  (r_q.req.mode32),
        .ea      (ea_w)
    );

    qps_reg_sel #(.RW(QPS_RW)) u_reg (
        .pair_field (r_q.req.rt),
        .second     (second_w),
        .big_endian (r_q.req.big_endian),
        .prefixed   (r_q.req.prefixed),
        .reg_num    (out_reg)
    );

    qps_trap_check #(.AW(QPS_AW), .RW(QPS_RW), .OFS(DW_OFS)) u_trap (
        .ea          (ea_w),
        .second      (second_w),
        .load        (r_q.req.load),
        .reserve     (r_q.req.reserve),
        .prefixed    (r_q.req.prefixed),
        .big_endian  (r_q.req.big_endian),
        .rt          (r_q.req.rt),
        .ra          (r_q.req.ra),
        .rb          (r_q.req.rb),
        .atomic_qw   (out_atomic_qw),
        .atomic_last (out_atomic_last),
        .align_trap  (out_align_trap),
        .illegal     (out_illegal)
    );

    always_comb begin
        trap_w     = out_align_trap | out_illegal;
        req_ready  = (r_q.st == SEQ_IDLE);
        out_valid  = (r_q.st != SEQ_IDLE);
        out_second = second_w;
        out_last   = out_valid && (second_w || trap_w);
        out_addr   = ea_w;
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            SEQ_IDLE: begin
                if (req_valid) begin
                    r_d.st             = SEQ_FIRST;
                    r_d.req.load       = req_load;
                    r_d.req.reserve    = req_reserve;
                    r_d.req.prefixed   = req_prefixed;
                    r_d.req.big_endian = req_big_endian;
                    r_d.req.mode32     = req_mode32;
                    r_d.req.ea         = req_ea;
                    r_d.req.rt         = req_rt;
                    r_d.req.ra         = req_ra;
                    r_d.req.rb         = req_rb;
                end
            end
            SEQ_FIRST: begin
                if (out_ready) begin
                    r_d.ea0 = ea_w;
                    r_d.st  = trap_w ? SEQ_IDLE : SEQ_SECOND;
                end
            end
            SEQ_SECOND: begin
                if (out_ready) begin
                    r_d.st = SEQ_IDLE;
                end
            end
            default: r_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/quad_pair_seq_chk.sv
module quad_pair_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic        out_second,
    input logic        out_last,
    input logic [63:0] out_addr,
    input logic [4:0]  out_reg,
    input logic        out_atomic_qw,
    input logic        out_atomic_last,
    input logic        out_align_trap,
    input logic        out_illegal
);
    // R1
    busy_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !req_ready);

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_addr) && $stable(out_reg) && $stable(out_second)));

    // R3
    second_addr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_second && !out_last) |=>
            (out_valid && out_second && out_addr[2:0] == $past(out_addr[2:0])));

    // R4
    reg_pair_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_second && !out_last) |=>
            (out_reg[4:1] == $past(out_reg[4:1]) && out_reg[0] != $past(out_reg[0])));

    // R5
    atomic_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_atomic_last) |-> (out_atomic_qw && out_second));

    // R10
    trap_ends_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && (out_align_trap || out_illegal)) |=> !out_valid);

    // R9
    illegal_first_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> !out_second);

endmodule

bind quad_pair_seq quad_pair_seq_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_ready       (req_ready),
    .out_valid       (out_valid),
    .out_ready       (out_ready),
    .out_second      (out_second),
    .out_last        (out_last),
    .out_addr        (out_addr),
    .out_reg         (out_reg),
    .out_atomic_qw   (out_atomic_qw),
    .out_atomic_last (out_atomic_last),
    .out_align_trap  (out_align_trap),
    .out_illegal     (out_illegal)
);

// File: tb/quad_pair_seq_bench.sv
module quad_pair_seq_bench;

    typedef struct packed {
        logic        ld;
        logic        rsv;
        logic        pfx;
        logic        be;
        logic        m32;
        logic [63:0] base;
        logic [4:0]  rt;
        logic [4:0]  ra;
        logic [4:0]  rb;
        logic [63:0] a0;
        logic [63:0] a1;
        logic [4:0]  r0;
        logic [4:0]  r1;
        logic        aqw;
        logic        trap;
        logic        ill;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        // aligned big-endian load: even then odd (R4, R5)
        '{1'b1,1'b0,1'b0,1'b1,1'b0, 64'h1000, 5'd4, 5'd3, 5'd0, 64'h1000, 64'h1008, 5'd4, 5'd5, 1'b1,1'b0,1'b0},
        // aligned little-endian non-prefixed load: odd then even (R4)
        '{1'b1,1'b0,1'b0,1'b0,1'b0, 64'h2000, 5'd6, 5'd1, 5'd0, 64'h2000, 64'h2008, 5'd7, 5'd6, 1'b1,1'b0,1'b0},
        // prefixed little-endian load: even first (R4)
        '{1'b1,1'b0,1'b1,1'b0,1'b0, 64'h3010, 5'd8, 5'd2, 5'd0, 64'h3010, 64'h3018, 5'd8, 5'd9, 1'b1,1'b0,1'b0},
        // misaligned LE store, RA==RT allowed for stores (R7, R8)
        '{1'b0,1'b0,1'b0,1'b0,1'b0, 64'h4008, 5'd10,5'd10,5'd0, 64'h4008, 64'h4010, 5'd11,5'd10,1'b0,1'b0,1'b0},
        // misaligned BE load, no trap (R7, R3 low bits)
        '{1'b1,1'b0,1'b0,1'b1,1'b0, 64'h5004, 5'd12,5'd1, 5'd0, 64'h5004, 64'h500C, 5'd12,5'd13,1'b0,1'b0,1'b0},
        // misaligned LE non-prefixed load: trap (R7)
        '{1'b1,1'b0,1'b0,1'b0,1'b0, 64'h6004, 5'd14,5'd1, 5'd0, 64'h6004, 64'h0,    5'd15,5'd0, 1'b0,1'b1,1'b0},
        // misaligned load-reserve (bit 3 set on first half): trap (R6)
        '{1'b1,1'b1,1'b0,1'b1,1'b0, 64'h7008, 5'd16,5'd1, 5'd2, 64'h7008, 64'h0,    5'd16,5'd0, 1'b0,1'b1,1'b0},
        // aligned store-conditional (R5, R6)
        '{1'b0,1'b1,1'b0,1'b1,1'b0, 64'h8000, 5'd18,5'd1, 5'd2, 64'h8000, 64'h8008, 5'd18,5'd19,1'b1,1'b0,1'b0},
        // load with RA==RT: illegal (R8)
        '{1'b1,1'b0,1'b0,1'b1,1'b0, 64'h9000, 5'd20,5'd20,5'd0, 64'h9000, 64'h0,    5'd20,5'd0, 1'b1,1'b0,1'b1},
        // odd pair field on a store: illegal (R9)
        '{1'b0,1'b0,1'b0,1'b1,1'b0, 64'hA000, 5'd21,5'd1, 5'd0, 64'hA000, 64'h0,    5'd21,5'd0, 1'b1,1'b0,1'b1},
        // load-reserve with RB==RT: illegal (R8)
        '{1'b1,1'b1,1'b0,1'b1,1'b0, 64'hB000, 5'd22,5'd1, 5'd22,64'hB000, 64'h0,    5'd22,5'd0, 1'b1,1'b0,1'b1},
        // 32-bit mode, second address wraps to zero (R2, R3)
        '{1'b0,1'b0,1'b0,1'b1,1'b1, 64'hFFFF_FFFF_FFFF_FFF8, 5'd24,5'd1,5'd0, 64'h0000_0000_FFFF_FFF8, 64'h0, 5'd24,5'd25,1'b0,1'b0,1'b0},
        // 32-bit mode masks upper bits (R2)
        '{1'b1,1'b0,1'b0,1'b1,1'b1, 64'h1234_5678_0000_0010, 5'd2,5'd1,5'd0, 64'h10, 64'h18, 5'd2, 5'd3, 1'b1,1'b0,1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_load = 1'b0;
    logic        req_reserve = 1'b0;
    logic        req_prefixed = 1'b0;
    logic        req_big_endian = 1'b0;
    logic        req_mode32 = 1'b0;
    logic [63:0] req_ea = '0;
    logic [4:0]  req_rt = '0;
    logic [4:0]  req_ra = '0;
    logic [4:0]  req_rb = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        out_second;
    logic        out_last;
    logic [63:0] out_addr;
    logic [4:0]  out_reg;
    logic        out_atomic_qw;
    logic        out_atomic_last;
    logic        out_align_trap;
    logic        out_illegal;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    quad_pair_seq u_quad_pair_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_load(req_load), .req_reserve(req_reserve),
        .req_prefixed(req_prefixed), .req_big_endian(req_big_endian),
        .req_mode32(req_mode32), .req_ea(req_ea),
        .req_rt(req_rt), .req_ra(req_ra), .req_rb(req_rb),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_second(out_second), .out_last(out_last),
        .out_addr(out_addr), .out_reg(out_reg),
        .out_atomic_qw(out_atomic_qw), .out_atomic_last(out_atomic_last),
        .out_align_trap(out_align_trap), .out_illegal(out_illegal)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        req_load       = v.ld;
        req_reserve    = v.rsv;
        req_prefixed   = v.pfx;
        req_big_endian = v.be;
        req_mode32     = v.m32;
        req_ea         = v.base;
        req_rt         = v.rt;
        req_ra         = v.ra;
        req_rb         = v.rb;
    endtask

    task automatic run_vec(input vec_t v);
        logic trapped;
        trapped = v.trap | v.ill;
        @(negedge clk);
        drive(v);
        req_valid = 1'b1;
        out_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1 busy req_ready", 64'(req_ready), 64'(0));
        chk("R2 first valid", 64'(out_valid), 64'(1));
        chk("R2 first second-flag", 64'(out_second), 64'(0));
        chk("R2 first addr", out_addr, v.a0);
        chk("R4 first reg", 64'(out_reg), 64'(v.r0));
        chk("R5 first atomic_qw", 64'(out_atomic_qw), 64'(v.aqw));
        chk("R5 first atomic_last", 64'(out_atomic_last), 64'(0));
        chk("R6 R7 first align trap", 64'(out_align_trap), 64'(v.trap));
        chk("R8 R9 first illegal", 64'(out_illegal), 64'(v.ill));
        chk("R10 first last", 64'(out_last), 64'(trapped));
        @(negedge clk);
        if (trapped) begin
            chk("R10 no second half", 64'(out_valid), 64'(0));
        end else begin
            chk("R3 second valid", 64'(out_valid), 64'(1));
            chk("R3 second flag", 64'(out_second), 64'(1));
            chk("R3 second addr", out_addr, v.a1);
            chk("R4 second reg", 64'(out_reg), 64'(v.r1));
            chk("R5 second atomic_qw", 64'(out_atomic_qw), 64'(v.aqw));
            chk("R5 second atomic_last", 64'(out_atomic_last), 64'(v.aqw));
            chk("R9 second illegal", 64'(out_illegal), 64'(0));
            chk("R10 second last", 64'(out_last), 64'(1));
            @(negedge clk);
            chk("R10 idle after pair", 64'(out_valid), 64'(0));
        end
        chk("R1 ready again", 64'(req_ready), 64'(1));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 reset out_valid", 64'(out_valid), 64'(0));
        chk("R12 reset req_ready", 64'(req_ready), 64'(1));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 idle out_valid", 64'(out_valid), 64'(0));

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i]);
        end

        // R11 stall between halves, R1 request while busy ignored
        @(negedge clk);
        drive(VECS[0]);
        req_valid = 1'b1;
        out_ready = 1'b0;
        @(negedge clk);
        req_rt = 5'd30;
        req_ea = 64'hDEAD_0000;
        for (int k = 0; k < 3; k++) begin
            chk("R11 stall valid", 64'(out_valid), 64'(1));
            chk("R11 stall addr", out_addr, 64'h1000);
            chk("R11 stall reg", 64'(out_reg), 64'(4));
            chk("R1 stall req_ready", 64'(req_ready), 64'(0));
            @(negedge clk);
        end
        req_valid = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        chk("R11 second after stall addr", out_addr, 64'h1008);
        chk("R11 second after stall reg", 64'(out_reg), 64'(5));
        out_ready = 1'b0;
        @(negedge clk);
        chk("R11 second held", out_addr, 64'h1008);
        out_ready = 1'b1;
        @(negedge clk);
        chk("R1 busy request not taken", 64'(out_valid), 64'(0));
        @(negedge clk);
        chk("R1 still idle", 64'(out_valid), 64'(0));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule